// File: doc/BRIEF.md
# Sixteen-Bit Timer/Counter with Compare, Capture and Center-Aligned PWM

This block is a 16-bit timer/counter peripheral for a small microcontroller. The count advances on a selectable time base: the system clock, one of five prescaled versions of it, or edges on an external input pin. The external pin is synchronized into the system clock domain before it is used. A stop setting freezes the count. Two compare channels watch the count. Each one raises a match flag and moves its own output pin. Channel A can also restart the count, which gives a programmable period. A capture unit latches the count when the selected edge arrives from a capture pin or from a comparator signal.

The same counter can run as a dual-slope up/down counter of 8, 9 or 10 bits. In that mode the two compare channels drive two independent center-aligned pulse outputs. Compare values written in this mode wait in a holding register and become active only when the count turns at its top, so no period is ever cut short. Software reaches the block through a small register bus whose reads are combinational. The status flags are cleared by writing ones to them. An interrupt line for each flag is gated by an external enable input.

Top module: `tmr16_timer`

## Requirements
- R1: CTRL (address 0) bits [2:0] select the time base: 0 stops the count, 1 counts every clock, and 2, 3, 4, 5 count once every 8, 64, 256 and 1024 clocks, taken from a free-running divider. Any window of N·m consecutive clocks therefore adds exactly m to the count.
- R2: Codes 6 and 7 count falling and rising edges of the external clock pin. The pin passes through a two-flop synchronizer, and each selected edge adds exactly one count when the pin is held for at least one clock between transitions.
- R3: When PWM is off, the counter goes from 0xFFFF to 0x0000 and sets the overflow flag (FLAGS bit 0).
- R4: A count step taken while the count equals compare A or compare B (addresses 2 and 3) sets FLAGS bit 1 or bit 2.
- R5: When CTRL bit 3 is set and PWM is off, a step taken from a count equal to compare A loads 0. The period is then compare A + 1 steps.
- R6: When PWM is off, each compare match applies the channel's action to its pin. The actions are CTRL[7:6] for A and CTRL[9:8] for B: 0 holds the pin, 1 toggles it, 2 drives it low, 3 drives it high.
- R7: CTRL[5:4] values 1, 2 and 3 select dual-slope PWM with a top of 255, 511 or 1023. The count runs 0 up to the top and back down to 0. The overflow flag is set on the step that leaves 0.
- R8: In PWM mode, action 2 drives the pin high while count < active compare, and action 3 drives the inverse of that. Actions 0 and 1 hold the pin low.
- R9: In PWM mode, a compare write goes to a holding register, which is also what a read returns. The active value takes the held value on the step at the top. When PWM is off, a write takes effect immediately.
- R10: A capture event copies the count into CAPT (address 4, read-only) and sets FLAGS bit 3. CTRL bit 10 selects the edge (1 = rising, 0 = falling). CTRL bit 11 selects the source (0 = capture pin, 1 = comparator input). The other edge and the unselected source have no effect.
- R11: Writing FLAGS (address 5) clears each flag whose data bit is 1 and leaves the rest unchanged. irq[i] is high exactly when flag i and irq_en[i] are both set.
- R12: After reset all registers, flags and pins are zero. A bus write to COUNT (address 1) takes priority over a count step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk_pin | input | 1 | External counting input (asynchronous) |
| cap_pin | input | 1 | Capture trigger pin (asynchronous) |
| cmp_in | input | 1 | Comparator output used as alternative capture source |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq_en | input | 4 | Interrupt enables: overflow, compare A, compare B, capture |
| irq | output | 4 | Interrupt requests, flag AND enable |
| oc_a | output | 1 | Compare channel A output pin |
| oc_b | output | 1 | Compare channel B output pin |

## Verification
Each prescale code runs for a window that is an exact multiple of its ratio. The expected count is then a single number whatever the divider phase, so a wrong tap or a double count shows up. Every PWM output level is checked against its arithmetic expectation over all 256 counts of the 8-bit range, in both polarities. Dual-slope runs in all three resolutions stop just before and just after the bottom, which separates the turn at the top from the restart at the bottom. Capture runs go through each edge and each source, alternating selected and unselected stimuli with distinct frozen counts, so a capture that should have been ignored changes the value that is read back.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int CNT_W  = 16;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;
    localparam int PRE_W  = 10;
    localparam int FLAG_N = 4;
    localparam int CTRL_W = 12;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMPA  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMPB  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CAPT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_FLAGS = 3'd5;

    localparam int FL_OVF = 0;
    localparam int FL_MA  = 1;
    localparam int FL_MB  = 2;
    localparam int FL_CAP = 3;

    typedef enum logic [2:0] {
        CS_STOP, CS_DIV1, CS_DIV8, CS_DIV64,
        CS_DIV256, CS_DIV1024, CS_EXT_FALL, CS_EXT_RISE
    } clk_sel_e;

    typedef enum logic [1:0] {
        OA_HOLD, OA_TOGGLE, OA_CLEAR, OA_SET
    } out_act_e;

    typedef enum logic [1:0] {
        PW_OFF, PW_8, PW_9, PW_10
    } pwm_res_e;

    typedef struct packed {
        logic     cap_src;
        logic     cap_rise;
        out_act_e act_b;
        out_act_e act_a;
        pwm_res_e pwm;
        logic     clr_a;
        clk_sel_e cs;
    } ctrl_t;

    function automatic logic [CNT_W-1:0] pwm_top(input pwm_res_e r);
        logic [CNT_W-1:0] t;
        case (r)
            PW_8:    t = CNT_W'(16'h00FF);
            PW_9:    t = CNT_W'(16'h01FF);
            PW_10:   t = CNT_W'(16'h03FF);
            default: t = '1;
        endcase
        return t;
    endfunction

    function automatic logic out_step(input out_act_e a, input logic cur);
        logic n;
        case (a)
            OA_TOGGLE: n = ~cur;
            OA_CLEAR:  n = 1'b0;
            OA_SET:    n = 1'b1;
            default:   n = cur;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tmr16_edge.sv
module tmr16_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], din};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/tmr16_clkgen.sv
module tmr16_clkgen
    import tmr16_pkg::*;
#(
    parameter int DIV_W = PRE_W
) (
    input  logic     clk,
    input  logic     rst,
    input  clk_sel_e cs,
    input  logic     ext_pin,
    output logic     tick
);
    logic [DIV_W-1:0] div_q;
    logic ext_rise, ext_fall;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    tmr16_edge #(.STAGES(2)) u_ext (
        .clk(clk), .rst(rst), .din(ext_pin), .rise(ext_rise), .fall(ext_fall)
    );

    always_comb begin
        case (cs)
            CS_DIV1:     tick = 1'b1;
            CS_DIV8:     tick = &div_q[2:0];
            CS_DIV64:    tick = &div_q[5:0];
            CS_DIV256:   tick = &div_q[7:0];
            CS_DIV1024:  tick = &div_q[9:0];
            CS_EXT_FALL: tick = ext_fall;
            CS_EXT_RISE: tick = ext_rise;
            default:     tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter
    import tmr16_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         pwm_on,
    input  logic [W-1:0] top,
    input  logic         clr_a,
    input  logic [W-1:0] cmpa_act,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt,
    output logic         load,
    output logic         ovf
);
    logic dir_up_q;

    assign load = pwm_on & tick & ~wr & dir_up_q & (cnt >= top);
    assign ovf  = tick & ~wr & (pwm_on ? (~dir_up_q & (cnt == '0)) : (cnt == '1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            dir_up_q <= 1'b1;
        end else begin
            if (!pwm_on) dir_up_q <= 1'b1;
            if (wr) begin
                cnt <= wdata;
            end else if (tick) begin
                if (pwm_on) begin
                    if (dir_up_q) begin
                        if (cnt >= top) begin
                            dir_up_q <= 1'b0;
                            cnt      <= top - 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end else begin
                        if (cnt == '0) begin
                            dir_up_q <= 1'b1;
                            cnt      <= W'(1);
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end else if (clr_a && cnt == cmpa_act) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tmr16_chan.sv
module tmr16_chan
    import tmr16_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         pwm_on,
    input  logic         load,
    input  logic         tick,
    input  logic [W-1:0] cnt,
    input  out_act_e     act,
    output logic [W-1:0] cmp_buf,
    output logic [W-1:0] cmp_act,
    output logic         match,
    output logic         pin
);
    logic oc_q;
    logic below;

    assign match = tick & (cnt == cmp_act);
    assign below = cnt < cmp_act;
    assign pin   = pwm_on ? (act[1] & (act[0] ^ below)) : oc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_buf <= '0;
            cmp_act <= '0;
            oc_q    <= 1'b0;
        end else begin
            if (wr) cmp_buf <= wdata;
            if (!pwm_on && wr)      cmp_act <= wdata;
            else if (pwm_on && load) cmp_act <= cmp_buf;
            if (!pwm_on && match)   oc_q <= out_step(act, oc_q);
        end
    end
endmodule

// File: rtl/tmr16_capture.sv
module tmr16_capture
    import tmr16_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_pin,
    input  logic         cmp_in,
    input  logic         rise_sel,
    input  logic         src_sel,
    input  logic [W-1:0] cnt,
    output logic         cap_evt,
    output logic [W-1:0] cap_val
);
    localparam int NSRC = 2;
    logic [NSRC-1:0] src_in, src_rise, src_fall, src_evt;

    assign src_in = {cmp_in, cap_pin};

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        tmr16_edge #(.STAGES(2)) u_sync (
            .clk(clk), .rst(rst), .din(src_in[g]),
            .rise(src_rise[g]), .fall(src_fall[g])
        );
        assign src_evt[g] = rise_sel ? src_rise[g] : src_fall[g];
    end

    assign cap_evt = src_evt[src_sel];

    always_ff @(posedge clk) begin
        if (rst)          cap_val <= '0;
        else if (cap_evt) cap_val <= cnt;
    end
endmodule

// File: rtl/tmr16_timer.sv
module tmr16_timer
    import tmr16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_clk_pin,
    input  logic              cap_pin,
    input  logic              cmp_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [FLAG_N-1:0] irq_en,
    output logic [FLAG_N-1:0] irq,
    output logic              oc_a,
    output logic              oc_b
);
    localparam int NCH = 2;

    ctrl_t              ctrl_q;
    logic [FLAG_N-1:0]  flags_q, flags_d;
    logic               tick, load, ovf, cap_evt, cnt_wr, pwm_on, clr_a;
    clk_sel_e           cs_sel;
    logic [CNT_W-1:0]   cnt, top_val, cap_val;
    logic [CNT_W-1:0]   cmp_buf [NCH];
    logic [CNT_W-1:0]   cmp_act [NCH];
    logic [CNT_W-1:0]   cmpa_act;
    logic [NCH-1:0]     match, pin, ch_wr;
    out_act_e           act [NCH];

    assign cs_sel   = ctrl_q.cs;
    assign clr_a    = ctrl_q.clr_a;
    assign pwm_on   = ctrl_q.pwm != PW_OFF;
    assign top_val  = pwm_top(ctrl_q.pwm);
    assign cnt_wr   = bus_wr && bus_addr == A_COUNT;
    assign ch_wr[0] = bus_wr && bus_addr == A_CMPA;
    assign ch_wr[1] = bus_wr && bus_addr == A_CMPB;
    assign act[0]   = ctrl_q.act_a;
    assign act[1]   = ctrl_q.act_b;
    assign cmpa_act = cmp_act[0];

    always_ff @(posedge clk) begin
        if (rst)                              ctrl_q <= '0;
        else if (bus_wr && bus_addr == A_CTRL) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end

    tmr16_clkgen u_clkgen (
        .clk(clk), .rst(rst), .cs(cs_sel), .ext_pin(ext_clk_pin), .tick(tick)
    );

    tmr16_counter u_counter (
        .clk(clk), .rst(rst), .tick(tick), .pwm_on(pwm_on), .top(top_val),
        .clr_a(clr_a), .cmpa_act(cmpa_act), .wr(cnt_wr), .wdata(bus_wdata),
        .cnt(cnt), .load(load), .ovf(ovf)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tmr16_chan u_chan (
            .clk(clk), .rst(rst), .wr(ch_wr[c]), .wdata(bus_wdata),
            .pwm_on(pwm_on), .load(load), .tick(tick), .cnt(cnt), .act(act[c]),
            .cmp_buf(cmp_buf[c]), .cmp_act(cmp_act[c]),
            .match(match[c]), .pin(pin[c])
        );
    end

    assign oc_a = pin[0];
    assign oc_b = pin[1];

    tmr16_capture u_capture (
        .clk(clk), .rst(rst), .cap_pin(cap_pin), .cmp_in(cmp_in),
        .rise_sel(ctrl_q.cap_rise), .src_sel(ctrl_q.cap_src), .cnt(cnt),
        .cap_evt(cap_evt), .cap_val(cap_val)
    );

    always_comb begin
        flags_d = flags_q;
        if (bus_wr && bus_addr == A_FLAGS) flags_d = flags_q & ~bus_wdata[FLAG_N-1:0];
        flags_d[FL_OVF] = flags_d[FL_OVF] | ovf;
        flags_d[FL_MA]  = flags_d[FL_MA]  | match[0];
        flags_d[FL_MB]  = flags_d[FL_MB]  | match[1];
        flags_d[FL_CAP] = flags_d[FL_CAP] | cap_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign irq = flags_q & irq_en;

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = DATA_W'(ctrl_q);
            A_COUNT: bus_rdata = cnt;
            A_CMPA:  bus_rdata = cmp_buf[0];
            A_CMPB:  bus_rdata = cmp_buf[1];
            A_CAPT:  bus_rdata = cap_val;
            A_FLAGS: bus_rdata = DATA_W'(flags_q);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr16_timer_chk.sv
module tmr16_timer_chk
    import tmr16_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input clk_sel_e         cs_sel,
    input logic             clr_a,
    input logic             pwm_on,
    input logic             tick,
    input logic             load,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] top_val,
    input logic [CNT_W-1:0] cmpa_act,
    input logic             cap_evt,
    input logic [CNT_W-1:0] cap_val
);
    p_stop_holds_r1: assert property (@(posedge clk) disable iff (rst)
        (cs_sel == CS_STOP && !cnt_wr) |=> $stable(cnt));

    p_clear_on_a_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && clr_a && !pwm_on && !cnt_wr && cnt == cmpa_act) |=> (cnt == '0));

    p_pwm_range_r7: assert property (@(posedge clk) disable iff (rst)
        (pwm_on && !cnt_wr && cnt <= top_val) |=> (cnt <= $past(top_val)));

    p_buffer_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (pwm_on && !load) |=> $stable(cmpa_act));

    p_capture_copy_r10: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> (cap_val == $past(cnt)));
endmodule

bind tmr16_timer tmr16_timer_chk u_chk (
    .clk(clk), .rst(rst), .cs_sel(cs_sel), .clr_a(clr_a), .pwm_on(pwm_on),
    .tick(tick), .load(load), .cnt_wr(cnt_wr), .cnt(cnt), .top_val(top_val),
    .cmpa_act(cmpa_act), .cap_evt(cap_evt), .cap_val(cap_val)
);

// File: tb/tmr16_timer_test.sv
`timescale 1ns/1ps
module tmr16_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_clk_pin = 1'b0;
    logic        cap_pin = 1'b0;
    logic        cmp_in = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  irq_en = '0;
    logic [3:0]  irq;
    logic        oc_a, oc_b;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    tmr16_timer uut (
        .clk(clk), .rst(rst), .ext_clk_pin(ext_clk_pin), .cap_pin(cap_pin),
        .cmp_in(cmp_in), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_en(irq_en),
        .irq(irq), .oc_a(oc_a), .oc_b(oc_b)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int pwm_expect(input int top, input int k);
        int m;
        m = k % (2 * top);
        return (m <= top) ? m : 2 * top - m;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] v;
        int ratio [5] = '{1, 8, 64, 256, 1024};
        int mult  [5] = '{37, 5, 4, 3, 2};

        do_reset();
        // R12: reset state
        rd(3'd0, v); chk("R12 ctrl after reset", v, 0);
        rd(3'd1, v); chk("R12 count after reset", v, 0);
        rd(3'd5, v); chk("R12 flags after reset", v, 0);
        chk("R12 pins after reset", {oc_a, oc_b}, 0);

        // R1: stopped time base
        wr(3'd1, 16'h0055);
        run(40);
        rd(3'd1, v); chk("R1 stop holds count", v, 16'h0055);

        // R1: every prescale ratio, window = ratio * mult
        for (int i = 0; i < 5; i++) begin
            wr(3'd0, 16'd0);
            wr(3'd1, 16'd0);
            wr(3'd0, 16'(i + 1));
            run(ratio[i] * mult[i]);
            rd(3'd1, v); chk($sformatf("R1 ratio %0d", ratio[i]), v, 16'(mult[i]));
        end

        // R2: external edges, rising then falling
        for (int e = 0; e < 2; e++) begin
            wr(3'd0, 16'd0);
            wr(3'd1, 16'd0);
            wr(3'd0, (e == 0) ? 16'd7 : 16'd6);
            for (int p = 0; p < 5; p++) begin
                ext_clk_pin = 1'b1; run(3);
                ext_clk_pin = 1'b0; run(3);
            end
            run(4);
            rd(3'd1, v); chk(e == 0 ? "R2 rising edges" : "R2 falling edges", v, 16'd5);
        end

        // R3/R4/R11: wrap and flags
        do_reset();
        wr(3'd1, 16'hFFFD);
        wr(3'd0, 16'd1);
        run(5);
        rd(3'd1, v); chk("R3 wrap count", v, 16'd2);
        rd(3'd5, v); chk("R3 R4 flags after wrap", v, 16'h0007);
        irq_en = 4'b0001;
        #1; chk("R11 irq gated by enable", irq, 4'b0001);
        wr(3'd5, 16'h0001);
        rd(3'd5, v); chk("R11 write one clears only ovf", v, 16'h0006);
        #1; chk("R11 irq after clear", irq, 4'b0000);
        irq_en = 4'b0000;

        // R4/R5/R6: clear-on-A period with toggle on B
        do_reset();
        wr(3'd2, 16'd9);
        wr(3'd3, 16'd3);
        wr(3'd0, 16'd1 | 16'h0008 | (16'd3 << 6) | (16'd1 << 8));
        run(25);
        rd(3'd1, v); chk("R5 period count", v, 16'd5);
        chk("R6 set action A", oc_a, 1'b1);
        chk("R6 toggle B three times", oc_b, 1'b1);
        rd(3'd5, v); chk("R4 match flags", v, 16'h0006);
        run(10);
        chk("R6 toggle B fourth time", oc_b, 1'b0);

        // R6: each action applied after pin was set high
        for (int a = 0; a < 4; a++) begin
            do_reset();
            wr(3'd2, 16'd9);
            wr(3'd0, 16'd1 | 16'h0008 | (16'd3 << 6));
            run(15);
            chk("R6 preset high", oc_a, 1'b1);
            wr(3'd0, 16'd1 | 16'h0008 | 16'(a << 6));
            run(10);
            rd(3'd1, v); chk("R5 count after action change", v, 16'd6);
            chk($sformatf("R6 action %0d", a), oc_a, (a == 0 || a == 3) ? 1'b1 : 1'b0);
        end

        // R7: dual-slope count in every resolution
        for (int r = 1; r <= 3; r++) begin
            int top;
            top = (1 << (7 + r)) - 1;
            do_reset();
            wr(3'd0, 16'd1 | 16'(r << 4));
            run(top + 45);
            rd(3'd1, v); chk($sformatf("R7 down slope res %0d", r), v, 16'(pwm_expect(top, top + 45)));
            rd(3'd5, v); chk("R7 no ovf before bottom", v & 16'h1, 0);
            run(top - 38);
            rd(3'd1, v); chk($sformatf("R7 after bottom res %0d", r), v, 16'(pwm_expect(top, 2 * top + 7)));
            rd(3'd5, v); chk("R7 ovf at bottom", v & 16'h1, 1);
        end

        // R8: exhaustive PWM output levels over the 8-bit range
        do_reset();
        wr(3'd2, 16'd100);
        wr(3'd3, 16'd37);
        wr(3'd0, (16'd1 << 4) | (16'd2 << 6) | (16'd3 << 8));
        for (int c = 0; c < 256; c++) begin
            wr(3'd1, 16'(c));
            chk("R8 non-inverted A", oc_a, (c < 100) ? 1'b1 : 1'b0);
            chk("R8 inverted B", oc_b, (c < 37) ? 1'b0 : 1'b1);
        end
        wr(3'd0, (16'd1 << 4) | (16'd1 << 6) | (16'd3 << 8));
        wr(3'd1, 16'd5);
        chk("R8 action 1 holds pin low", oc_a, 1'b0);

        // R9: buffered compare in PWM
        do_reset();
        wr(3'd2, 16'd100);
        wr(3'd0, (16'd1 << 4) | (16'd2 << 6));
        wr(3'd1, 16'd50);
        chk("R9 level with active 100", oc_a, 1'b1);
        wr(3'd2, 16'd20);
        chk("R9 write held in buffer", oc_a, 1'b1);
        rd(3'd2, v); chk("R9 readback of buffer", v, 16'd20);
        wr(3'd0, 16'd1 | (16'd1 << 4) | (16'd2 << 6));
        run(400);
        rd(3'd1, v); chk("R9 count after top", v, 16'd60);
        chk("R9 new compare active after top", oc_a, 1'b0);

        // R10: capture edges and sources
        do_reset();
        wr(3'd1, 16'h1234);
        wr(3'd0, 16'd1 << 10);
        cap_pin = 1'b1; run(4);
        rd(3'd4, v); chk("R10 rising pin capture", v, 16'h1234);
        rd(3'd5, v); chk("R10 capture flag", v, 16'h0008);
        wr(3'd5, 16'h0008);
        wr(3'd1, 16'h5678);
        cap_pin = 1'b0; run(4);
        rd(3'd4, v); chk("R10 falling ignored in rising mode", v, 16'h1234);
        rd(3'd5, v); chk("R10 no flag on ignored edge", v, 16'h0000);
        wr(3'd0, 16'd0);
        cap_pin = 1'b1; run(4);
        rd(3'd4, v); chk("R10 rising ignored in falling mode", v, 16'h1234);
        wr(3'd1, 16'h9ABC);
        cap_pin = 1'b0; run(4);
        rd(3'd4, v); chk("R10 falling pin capture", v, 16'h9ABC);
        wr(3'd0, (16'd1 << 11) | (16'd1 << 10));
        wr(3'd1, 16'h0F0F);
        cap_pin = 1'b1; run(4);
        rd(3'd4, v); chk("R10 pin ignored with comparator source", v, 16'h9ABC);
        cmp_in = 1'b1; run(4);
        rd(3'd4, v); chk("R10 comparator capture", v, 16'h0F0F);

        summary();
        $finish;
    end
endmodule